// File: doc/BRIEF.md
# Suspend and Wake Status Register

This block is one 8-bit register of a USB device controller's register file. It records whether the device is suspended, what ended the most recent suspend, whether the internal clocks have come up since power-on, and which package the die sits in. It also holds four firmware-set enables. Two of them are for optional features. One arms the suspend lockout. The last one drives the pull-up that signals connection to the host.

Firmware reads the register through a simple strobe port, and the data returns in the same cycle. Firmware can change only the low four bits. Hardware reset and software reset act differently. A hardware reset clears everything and then samples the package strap. A software reset clears the writable bits and the wake cause, but the initialised, suspended and package bits keep their values. The remote wake-up pin is asynchronous and active low, so it passes through a two-stage synchroniser before the block uses it.

Top module: `susp_wake_reg`

## Requirements
- R1: Bit order from bit 7 down to bit 0 is: wake cause, initialised, suspended, package ID, feature enable, board-feature enable, lockout enable, pull-up enable. While hardware reset is asserted and after its release, every bit reads 0 except bit 4, which reads the package strap.
- R2: A cycle with `regWrEn` high loads `regWrData[3:0]` into bits 3..0, and the new value is visible from the next cycle. Written values in bits 7..4 have no effect.
- R3: With `regRdEn` high, `regRdData` shows the current register value in the same cycle. With `regRdEn` low, `regRdData` is 0.
- R4: Bit 7 reads 0 whenever bit 3 is 0. The stored wake cause is kept, and it reappears when bit 3 is set again.
- R5: The first wake event after suspend entry updates the wake cause. A remote wake-up (`rwakeN` low after two synchroniser flops) sets it to 1. Later events in the same suspend period leave it unchanged.
- R6: A global resume or a bus reset as the first wake event clears the wake cause to 0. This also holds when a synchronised remote wake-up arrives in the same cycle.
- R7: Bit 6 becomes 1 in the cycle after `clkRunning` is first seen high, and it stays 1 until the next hardware reset. Software reset does not change it.
- R8: Bit 5 becomes 1 in the cycle after `suspendEnter` and returns to 0 in the cycle after `resumeDone`.
- R9: Bit 4 captures `pkgStrap` on the first clock edge after hardware reset is released. Later changes of the strap do not affect it.
- R10: `swRst` clears bits 3..0 and the stored wake cause in the next cycle, and it takes priority over a write in the same cycle. Bits 6..4 are unchanged.
- R11: `pullUpOe` and `pullUpOut` both equal bit 0. When bit 0 is 0 the pin is released (output enable low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| hwRstN | input | 1 | Hardware reset, active low, asynchronous |
| swRst | input | 1 | Software reset, synchronous, active high |
| clkRunning | input | 1 | Internal clocks are running |
| suspendEnter | input | 1 | Pulse: device enters suspend |
| resumeDone | input | 1 | Pulse: resume sequence finished, clocks back |
| rwakeN | input | 1 | Remote wake-up request pin, active low, asynchronous |
| globalResume | input | 1 | Pulse: host resume signalling detected |
| busReset | input | 1 | Pulse: USB bus reset detected |
| pkgStrap | input | 1 | Package identification strap |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 8 | Write data |
| regRdEn | input | 1 | Register read strobe |
| regRdData | output | 8 | Read data |
| featEn | output | 1 | Feature enable (bit 3) |
| boardFeatEn | output | 1 | Board-feature enable (bit 2) |
| lockoutEn | output | 1 | Suspend lockout enable (bit 1) |
| pullUpOut | output | 1 | Pull-up pin drive value |
| pullUpOe | output | 1 | Pull-up pin output enable |

## Verification
Four rules are asserted on every cycle: the pull-up pin follows bit 0 in every read, bit 7 is hidden while the feature enable is low, the enables load from a write, and software reset clears the enables. The wake-cause rules cannot be checked that way, because they depend on the order of events over a whole suspend period and on the synchroniser delay. These are the first-event rule, priority of a global wake in the same cycle, and a cause that survives while it is hidden. The bench covers them with directed sequences. It also checks strap sampling at reset release and the survival of status bits across software reset. Random writes, software resets and reads are compared against a bench model.

// File: rtl/susp_wake_pkg.sv
package susp_wake_pkg;
  localparam int REG_W     = 8;
  localparam int CAUSE_BIT = 7;
  localparam int INIT_BIT  = 6;
  localparam int SUSP_BIT  = 5;
  localparam int PKG_BIT   = 4;
  localparam int RW_W      = 4;

  typedef struct packed {
    logic wrLow;
    logic swClr;
    logic setCause;
    logic clrCause;
    logic setInit;
    logic setSusp;
    logic clrSusp;
    logic capPkg;
  } strobes_t;
endpackage

// File: rtl/susp_wake_ctrl.sv
module susp_wake_ctrl
  import susp_wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     hwRstN,
  input  logic     swRst,
  input  logic     clkRunning,
  input  logic     suspendEnter,
  input  logic     resumeDone,
  input  logic     rwakeN,
  input  logic     globalResume,
  input  logic     busReset,
  input  logic     regWrEn,
  output strobes_t stb
);
  logic [SYNC_STAGES-1:0] syncQ;
  logic armed;
  logic rstDone;
  logic remoteReq;
  logic globalReq;

  generate
    genvar g;
    for (g = 0; g < SYNC_STAGES; g++) begin : gSync
      if (g == 0) begin : gFirst
        always_ff @(posedge clk or negedge hwRstN)
          if (!hwRstN) syncQ[0] <= 1'b1;
          else         syncQ[0] <= rwakeN;
      end else begin : gNext
        always_ff @(posedge clk or negedge hwRstN)
          if (!hwRstN) syncQ[g] <= 1'b1;
          else         syncQ[g] <= syncQ[g-1];
      end
    end
  endgenerate

  assign remoteReq = ~syncQ[SYNC_STAGES-1];
  assign globalReq = globalResume | busReset;

  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN) begin
      armed   <= 1'b0;
      rstDone <= 1'b0;
    end else begin
      rstDone <= 1'b1;
      if (suspendEnter)
        armed <= 1'b1;
      else if (resumeDone || (armed && (remoteReq || globalReq)))
        armed <= 1'b0;
    end
  end

  always_comb begin
    stb          = '0;
    stb.wrLow    = regWrEn;
    stb.swClr    = swRst;
    stb.clrCause = armed & globalReq;
    stb.setCause = armed & remoteReq & ~globalReq;
    stb.setInit  = clkRunning;
    stb.setSusp  = suspendEnter;
    stb.clrSusp  = resumeDone;
    stb.capPkg   = ~rstDone;
  end
endmodule

// File: rtl/susp_wake_dp.sv
module susp_wake_dp
  import susp_wake_pkg::*;
(
  input  logic             clk,
  input  logic             hwRstN,
  input  strobes_t         stb,
  input  logic [REG_W-1:0] wrData,
  input  logic             pkgStrap,
  output logic [REG_W-1:0] regVal
);
  logic [RW_W-1:0] rwQ;
  logic causeQ, initQ, suspQ, pkgQ, pkgValid;
  logic pkgView;

  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN) begin
      rwQ    <= '0;
      causeQ <= 1'b0;
    end else if (stb.swClr) begin
      rwQ    <= '0;
      causeQ <= 1'b0;
    end else begin
      if (stb.wrLow)         rwQ    <= wrData[RW_W-1:0];
      if (stb.clrCause)      causeQ <= 1'b0;
      else if (stb.setCause) causeQ <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge hwRstN) begin
    if (!hwRstN) begin
      initQ    <= 1'b0;
      suspQ    <= 1'b0;
      pkgQ     <= 1'b0;
      pkgValid <= 1'b0;
    end else begin
      if (stb.setInit) initQ <= 1'b1;
      if (stb.setSusp)      suspQ <= 1'b1;
      else if (stb.clrSusp) suspQ <= 1'b0;
      if (stb.capPkg) begin
        pkgQ     <= pkgStrap;
        pkgValid <= 1'b1;
      end
    end
  end

  assign pkgView = pkgValid ? pkgQ : pkgStrap;

  always_comb begin
    regVal            = '0;
    regVal[RW_W-1:0]  = rwQ;
    regVal[PKG_BIT]   = pkgView;
    regVal[SUSP_BIT]  = suspQ;
    regVal[INIT_BIT]  = initQ;
    regVal[CAUSE_BIT] = causeQ & rwQ[RW_W-1];
  end
endmodule

// File: rtl/susp_wake_reg.sv
module susp_wake_reg
  import susp_wake_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       hwRstN,
  input  logic       swRst,
  input  logic       clkRunning,
  input  logic       suspendEnter,
  input  logic       resumeDone,
  input  logic       rwakeN,
  input  logic       globalResume,
  input  logic       busReset,
  input  logic       pkgStrap,
  input  logic       regWrEn,
  input  logic [7:0] regWrData,
  input  logic       regRdEn,
  output logic [7:0] regRdData,
  output logic       featEn,
  output logic       boardFeatEn,
  output logic       lockoutEn,
  output logic       pullUpOut,
  output logic       pullUpOe
);
  strobes_t stb;
  logic [REG_W-1:0] regVal;

  susp_wake_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .hwRstN(hwRstN), .swRst(swRst), .clkRunning(clkRunning),
    .suspendEnter(suspendEnter), .resumeDone(resumeDone), .rwakeN(rwakeN),
    .globalResume(globalResume), .busReset(busReset), .regWrEn(regWrEn),
    .stb(stb)
  );

  susp_wake_dp dp_i (
    .clk(clk), .hwRstN(hwRstN), .stb(stb), .wrData(regWrData),
    .pkgStrap(pkgStrap), .regVal(regVal)
  );

  assign regRdData   = regRdEn ? regVal : '0;
  assign featEn      = regVal[3];
  assign boardFeatEn = regVal[2];
  assign lockoutEn   = regVal[1];
  assign pullUpOut   = regVal[0];
  assign pullUpOe    = regVal[0];
endmodule

// File: rtl/susp_wake_chk.sv
module susp_wake_chk (
  input logic       clk,
  input logic       hwRstN,
  input logic       swRst,
  input logic       regWrEn,
  input logic [7:0] regWrData,
  input logic       regRdEn,
  input logic [7:0] regRdData,
  input logic       featEn,
  input logic       boardFeatEn,
  input logic       lockoutEn,
  input logic       pullUpOut,
  input logic       pullUpOe
);
  // R11
  pullup_follows_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    regRdEn |-> (regRdData[0] == pullUpOe) && (pullUpOut == pullUpOe));

  // R4
  cause_hidden_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    (regRdEn && !featEn) |-> !regRdData[7]);

  // R2
  write_loads_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    (regWrEn && !swRst) |=> {featEn, boardFeatEn, lockoutEn, pullUpOe} == $past(regWrData[3:0]));

  // R10
  swreset_clears_chk: assert property (@(posedge clk) disable iff (!hwRstN)
    swRst |=> !featEn && !boardFeatEn && !lockoutEn && !pullUpOe);
endmodule

bind susp_wake_reg susp_wake_chk chk_i (
  .clk(clk), .hwRstN(hwRstN), .swRst(swRst), .regWrEn(regWrEn),
  .regWrData(regWrData), .regRdEn(regRdEn), .regRdData(regRdData),
  .featEn(featEn), .boardFeatEn(boardFeatEn), .lockoutEn(lockoutEn),
  .pullUpOut(pullUpOut), .pullUpOe(pullUpOe)
);

// File: tb/susp_wake_reg_tb.sv
`timescale 1ns/1ps
module susp_wake_reg_tb_top;
  logic clk = 1'b0;
  logic hwRstN = 1'b0;
  logic swRst = 0, clkRunning = 0, suspendEnter = 0, resumeDone = 0;
  logic rwakeN = 1, globalResume = 0, busReset = 0, pkgStrap = 1;
  logic regWrEn = 0, regRdEn = 0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic featEn, boardFeatEn, lockoutEn, pullUpOut, pullUpOe;

  int compared = 0;
  int mismatched = 0;

  // bench model
  logic [3:0] mRw = '0;
  logic mCause = 0, mInit = 0, mSusp = 0, mPkg = 1;

  always #5 clk = ~clk;

  susp_wake_reg dut_i (
    .clk(clk), .hwRstN(hwRstN), .swRst(swRst), .clkRunning(clkRunning),
    .suspendEnter(suspendEnter), .resumeDone(resumeDone), .rwakeN(rwakeN),
    .globalResume(globalResume), .busReset(busReset), .pkgStrap(pkgStrap),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdEn(regRdEn),
    .regRdData(regRdData), .featEn(featEn), .boardFeatEn(boardFeatEn),
    .lockoutEn(lockoutEn), .pullUpOut(pullUpOut), .pullUpOe(pullUpOe)
  );

  function automatic logic [7:0] expRead();
    return {mCause & mRw[3], mInit, mSusp, mPkg, mRw};
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // called at a negedge; samples combinational read data
  task automatic readChk(input string req);
    regRdEn = 1'b1;
    #1;
    check(req, regRdData, expRead());
    check({req, " pins"}, {3'b0, featEn, boardFeatEn, lockoutEn, pullUpOut, pullUpOe},
          {3'b0, mRw[3:1], mRw[0], mRw[0]});
    regRdEn = 1'b0;
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    regWrEn = 1'b1; regWrData = d;
    cyc();
    regWrEn = 1'b0;
    mRw = d[3:0];
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    cyc();
    s = 1'b0;
  endtask

  initial begin
    #2_000_000;
    mismatched++;
    compared++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    @(negedge clk);
    // R1: during reset, strap visible, all else 0
    readChk("R1 in reset");
    cyc();
    hwRstN = 1'b1;
    cyc();
    readChk("R1 after reset");
    // R9: strap change after capture ignored
    pkgStrap = 1'b0;
    cyc();
    readChk("R9 strap held");
    // R3: no read strobe gives zero
    #1 check("R3 idle read", regRdData, 8'h00);

    // R2: read-only bits ignore writes
    wr(8'hF5);
    readChk("R2 ro ignored");
    wr(8'h0A);
    readChk("R2 rw loaded");
    // R11
    wr(8'h01);
    readChk("R11 pull-up driven");
    wr(8'h00);
    readChk("R11 pull-up released");

    // R7: init
    cyc();
    readChk("R7 before clocks");
    clkRunning = 1'b1; cyc(); mInit = 1;
    readChk("R7 init set");
    clkRunning = 1'b0; cyc();
    readChk("R7 init sticky");

    // R8 / R5: remote wake
    wr(8'h08);
    pulse(suspendEnter); mSusp = 1;
    readChk("R8 suspended");
    rwakeN = 1'b0;
    cyc(); cyc(); cyc();
    mCause = 1;
    readChk("R5 remote wake sets cause");
    rwakeN = 1'b1;
    cyc(); cyc();
    pulse(resumeDone); mSusp = 0;
    readChk("R8 resumed");

    // R4: hidden while feature off, retained
    wr(8'h00);
    readChk("R4 hidden");
    wr(8'h08);
    readChk("R4 retained");

    // R6: global resume clears; later remote ignored (R5 first event)
    pulse(suspendEnter); mSusp = 1;
    pulse(globalResume); mCause = 0;
    readChk("R6 global clears");
    rwakeN = 1'b0; cyc(); cyc(); cyc(); cyc();
    readChk("R5 later event ignored");
    rwakeN = 1'b1; cyc(); cyc();
    pulse(resumeDone); mSusp = 0;

    // set cause again, then simultaneous remote + bus reset
    pulse(suspendEnter); mSusp = 1;
    rwakeN = 1'b0; cyc(); cyc(); cyc(); mCause = 1;
    readChk("R5 set again");
    rwakeN = 1'b1; cyc(); cyc();
    pulse(resumeDone); mSusp = 0;
    pulse(suspendEnter); mSusp = 1;
    rwakeN = 1'b0;
    @(posedge clk); @(posedge clk); @(negedge clk);
    busReset = 1'b1;
    cyc();
    busReset = 1'b0; mCause = 0;
    readChk("R6 global wins same cycle");
    cyc(); cyc();
    readChk("R6 stays cleared");
    rwakeN = 1'b1;

    // set cause while suspended, then sw reset: R10
    pulse(resumeDone); mSusp = 0;
    pulse(suspendEnter); mSusp = 1;
    rwakeN = 1'b0; cyc(); cyc(); cyc(); mCause = 1;
    rwakeN = 1'b1;
    wr(8'h0F);
    readChk("R10 before sw reset");
    regWrEn = 1'b1; regWrData = 8'h0E; swRst = 1'b1;
    cyc();
    regWrEn = 1'b0; swRst = 1'b0;
    mRw = '0; mCause = 0;
    readChk("R10 sw reset wins, status kept");
    wr(8'h08);
    readChk("R10 cause cleared");

    // random writes / sw resets / reads
    for (int i = 0; i < 400; i++) begin
      automatic int op = $urandom_range(0, 9);
      automatic logic [7:0] d = 8'($urandom);
      if (op < 5) begin
        wr(d);
      end else if (op == 5) begin
        regWrEn = $urandom_range(0, 1); regWrData = d; swRst = 1'b1;
        cyc();
        regWrEn = 1'b0; swRst = 1'b0;
        mRw = '0; mCause = 0;
      end else begin
        readChk("R2 R3 R10 random");
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule